// File: doc/BRIEF.md
# Serial-Loaded Bank Control Registers

This block is a register file for the cartridge side of a game console. The host processor can only reach it through byte writes into the upper 32 KB of its address space, and only one data bit of each byte matters. Five writes in a row build up a 5-bit value in a hidden shift buffer. The fifth write then copies that value into one of four 5-bit control registers. Address bits 14:13 of the fifth write pick the register: a mode register, two character-bank registers and a program-bank register. The register outputs feed the address translation logic next to this block, which is not part of this project.

A write with data bit 7 set does not load anything. It aborts any load in progress and sets the two mode bits that select 16 KB program banking with the lower slot swappable. Some processor instructions issue a dummy write one cycle before the real one. To reject those, each write carries the processor's free-running cycle count. A write is dropped when its count is within one cycle of the count of the previous write, and the stored count is refreshed on every write, including dropped ones.

The upstream decoder asserts the write strobe only for addresses in the 0x8000–0xFFFF window.

Top module: `serial_bank_regs`

## Requirements
- R1: After reset the registers read mode = 0x0C, character bank 0 = 0x00, character bank 1 = 0x00 and program bank = 0x10.
- R2: Five accepted writes with data bit 7 clear load the registers least significant bit first: data bit 0 of the first write becomes register bit 0, and data bit 0 of the fifth write becomes register bit 4. The new value appears one clock after the fifth write.
- R3: Address bits 14:13 of the fifth write alone pick the destination: 0 mode, 1 character bank 0, 2 character bank 1, 3 program bank. Only that register changes.
- R4: Data bits 6:1 of a write have no effect on any register.
- R5: An accepted write with data bit 7 set ORs 0x0C into the mode register and leaves every other register bit unchanged. It also discards the partial load, so the next accepted write counts as the first of five.
- R6: A write whose cycle stamp differs from the previous write's stamp by less than 2 in absolute value has no effect. This holds when the stamp goes backwards too.
- R7: The stored stamp is replaced on every write, including a dropped one. So in a chain of stamps each one cycle apart, every write after the first is dropped.
- R8: The first write after reset is accepted whatever its stamp.
- R9: The stamp is a signed 32-bit count. The difference is formed without wrap-around, so stamps 0x7FFFFFFF followed by 0x80000000 count as far apart.
- R10: With the write strobe low, no register changes.
- R11: After a commit the shift buffer is empty, so a sixth write begins a new five-write load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the 0x8000–0xFFFF window, one clock per write |
| addr_sel | input | 2 | Address bits 14:13 of the write |
| wr_data | input | 8 | Write data byte; bit 7 is the abort flag, bit 0 the serial bit |
| cyc_stamp | input | 32 | Signed processor cycle count of the write |
| mode_q | output | 5 | Mode register |
| chr0_q | output | 5 | Character bank register 0 |
| chr1_q | output | 5 | Character bank register 1 |
| prg_q | output | 5 | Program bank register |

## Verification
Directed loads send distinct bit patterns to each address select. They show whether bits land least significant first and whether only the addressed register moves. They also use noisy upper data bits, which exposes any leak from bits 6:1. Stamp sequences one cycle apart, going backwards, equal to the reset value and spanning the signed wrap separate three things: the absolute-difference test, the refresh of the stored stamp on dropped writes, and the widened subtraction. Aborts in the middle of a load and a sixth write after a commit show that the partial buffer is cleared. Long runs of random writes with random stamp gaps then mix all of these, checked against a bench model of the requirements.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int REG_W     = 5;
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int CNT_W     = $clog2(REG_W + 1);
    localparam int DATA_W    = 8;
    localparam int FLAG_BIT  = 7;
    localparam int STAMP_W   = 32;
    localparam int MIN_GAP   = 2;

    localparam logic [REG_W-1:0] MODE_FORCE = REG_W'(5'b01100);

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 2'd0,
        SEL_CHR0 = 2'd1,
        SEL_CHR1 = 2'd2,
        SEL_PRG  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
    } shift_st_t;

    typedef struct packed {
        logic accept;
        logic flag;
        logic din;
    } wr_evt_t;

    function automatic logic [REG_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return MODE_FORCE;
            3:       return REG_W'(5'b10000);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sreg_write_filter.sv
module sreg_write_filter
    import sreg_pkg::*;
#(
    parameter int STAMP_BITS = STAMP_W,
    parameter int GAP_MIN    = MIN_GAP
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic signed [STAMP_BITS-1:0] stamp,
    output logic                         accept
);
    localparam int DIFF_W = STAMP_BITS + 1;

    logic signed [STAMP_BITS-1:0] last_q;
    logic                         seen_q;
    logic signed [DIFF_W-1:0]     diff;
    logic        [DIFF_W-1:0]     gap;

    always_comb begin
        diff   = {stamp[STAMP_BITS-1], stamp} - {last_q[STAMP_BITS-1], last_q};
        gap    = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);
        accept = wr_en && (!seen_q || (gap >= DIFF_W'(GAP_MIN)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '1;
            seen_q <= 1'b0;
        end else if (wr_en) begin
            last_q <= stamp;
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_evt_t          evt,
    output logic             commit,
    output logic             abort,
    output logic [REG_W-1:0] commit_val,
    output logic [CNT_W-1:0] cnt_o
);
    shift_st_t        st_q;
    logic [REG_W-1:0] nxt_bits;
    logic             last_bit;

    always_comb begin
        nxt_bits   = {evt.din, st_q.bits[REG_W-1:1]};
        last_bit   = (st_q.cnt == CNT_W'(REG_W - 1));
        commit     = evt.accept && !evt.flag && last_bit;
        abort      = evt.accept && evt.flag;
        commit_val = nxt_bits;
        cnt_o      = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (evt.accept) begin
            if (evt.flag || last_bit) begin
                st_q <= '0;
            end else begin
                st_q.bits <= nxt_bits;
                st_q.cnt  <= st_q.cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                commit,
    input  logic                                abort,
    input  reg_sel_e                            sel,
    input  logic [REG_W-1:0]                    val,
    output logic [NUM_REGS-1:0][REG_W-1:0]      regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL = reset_value(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= RST_VAL;
            end else if (commit && (sel == reg_sel_e'(i))) begin
                regs_q[i] <= val;
            end else if (abort && (i == 0)) begin
                regs_q[i] <= regs_q[i] | MODE_FORCE;
            end
        end
    end
endmodule

// File: rtl/serial_bank_regs.sv
module serial_bank_regs
    import sreg_pkg::*;
#(
    parameter int STAMP_BITS = STAMP_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             addr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic signed [STAMP_BITS-1:0] cyc_stamp,
    output logic [REG_W-1:0]             mode_q,
    output logic [REG_W-1:0]             chr0_q,
    output logic [REG_W-1:0]             chr1_q,
    output logic [REG_W-1:0]             prg_q
);
    logic                              wr_ok;
    logic                              do_commit;
    logic                              do_abort;
    logic [REG_W-1:0]                  commit_val;
    logic [CNT_W-1:0]                  shift_cnt;
    wr_evt_t                           evt;
    logic [NUM_REGS-1:0][REG_W-1:0]    regs;

    sreg_write_filter #(
        .STAMP_BITS (STAMP_BITS),
        .GAP_MIN    (MIN_GAP)
    ) u_filter (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .stamp  (cyc_stamp),
        .accept (wr_ok)
    );

    always_comb begin
        evt.accept = wr_ok;
        evt.flag   = wr_data[FLAG_BIT];
        evt.din    = wr_data[0];
    end

    sreg_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .commit     (do_commit),
        .abort      (do_abort),
        .commit_val (commit_val),
        .cnt_o      (shift_cnt)
    );

    sreg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .commit (do_commit),
        .abort  (do_abort),
        .sel    (reg_sel_e'(addr_sel)),
        .val    (commit_val),
        .regs_q (regs)
    );

    assign mode_q = regs[SEL_MODE];
    assign chr0_q = regs[SEL_CHR0];
    assign chr1_q = regs[SEL_CHR1];
    assign prg_q  = regs[SEL_PRG];
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker
    import sreg_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [DATA_W-1:0]         wr_data,
    input logic signed [STAMP_W-1:0] cyc_stamp,
    input logic                      wr_ok,
    input logic [CNT_W-1:0]          shift_cnt,
    input logic [REG_W-1:0]          mode_q,
    input logic [REG_W-1:0]          chr0_q,
    input logic [REG_W-1:0]          chr1_q,
    input logic [REG_W-1:0]          prg_q
);
    logic signed [STAMP_W-1:0] chk_last;
    logic                      chk_seen;
    longint                    chk_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_last <= '0;
            chk_seen <= 1'b0;
        end else if (wr_en) begin
            chk_last <= cyc_stamp;
            chk_seen <= 1'b1;
        end
    end

    always_comb begin
        chk_gap = longint'(cyc_stamp) - longint'(chk_last);
        if (chk_gap < 0) chk_gap = -chk_gap;
    end

    // R10: quiet bus keeps every register
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mode_q) && $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q)));

    // R6: a stamp within one cycle of the previous one is refused
    assert_gap_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && chk_seen && (chk_gap < 2)) |-> !wr_ok);

    // R8: the first write after reset passes the filter
    assert_first_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !chk_seen) |-> wr_ok);

    // R5: abort forces the two mode bits and nothing else
    assert_flag_force_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_data[FLAG_BIT]) |=>
            (mode_q[3:2] == 2'b11) && (mode_q[4] == $past(mode_q[4])) &&
            (mode_q[1:0] == $past(mode_q[1:0])) &&
            $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q));

    // R3: at most one register moves per clock
    assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({mode_q != $past(mode_q), chr0_q != $past(chr0_q),
                    chr1_q != $past(chr1_q), prg_q != $past(prg_q)}) <= 1);

    // R11: the shift count never passes four
    assert_cnt_range_R11: assert property (@(posedge clk) disable iff (rst)
        shift_cnt <= CNT_W'(REG_W - 1));
endmodule

bind serial_bank_regs sreg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cyc_stamp (cyc_stamp),
    .wr_ok     (wr_ok),
    .shift_cnt (shift_cnt),
    .mode_q    (mode_q),
    .chr0_q    (chr0_q),
    .chr1_q    (chr1_q),
    .prg_q     (prg_q)
);

// File: tb/serial_bank_regs_bench.sv
`timescale 1ns/1ps
module serial_bank_regs_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        addr_sel = '0;
    logic [7:0]        wr_data = '0;
    logic signed [31:0] cyc_stamp = '0;
    logic [4:0]        mode_q, chr0_q, chr1_q, prg_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0]         m_regs [4];
    logic [4:0]         m_buf;
    int                 m_cnt;
    logic signed [31:0] m_last;
    bit                 m_seen;
    longint             now_stamp;

    always #10 clk = ~clk;

    serial_bank_regs u_serial_bank_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr_sel  (addr_sel),
        .wr_data   (wr_data),
        .cyc_stamp (cyc_stamp),
        .mode_q    (mode_q),
        .chr0_q    (chr0_q),
        .chr1_q    (chr1_q),
        .prg_q     (prg_q)
    );

    function automatic bit gap_ok(logic signed [31:0] s, logic signed [31:0] l, bit seen);
        longint g = longint'(s) - longint'(l);
        if (g < 0) g = -g;
        return !seen || (g >= 2);
    endfunction

    task automatic model_reset();
        m_regs[0] = 5'h0C; m_regs[1] = 5'h00; m_regs[2] = 5'h00; m_regs[3] = 5'h10;
        m_buf = '0; m_cnt = 0; m_seen = 1'b0; m_last = -1;
    endtask

    task automatic model_write(logic [1:0] sel, logic [7:0] d, logic signed [31:0] s);
        bit ok = gap_ok(s, m_last, m_seen);
        m_last = s;
        m_seen = 1'b1;
        if (ok) begin
            if (d[7]) begin
                m_buf = '0; m_cnt = 0;
                m_regs[0] = m_regs[0] | 5'h0C;
            end else begin
                m_buf = {d[0], m_buf[4:1]};
                m_cnt++;
                if (m_cnt == 5) begin
                    m_regs[sel] = m_buf;
                    m_buf = '0; m_cnt = 0;
                end
            end
        end
    endtask

    task automatic check_one(string tag, string name, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check_one(tag, "mode", mode_q, m_regs[0]);
        check_one(tag, "chr0", chr0_q, m_regs[1]);
        check_one(tag, "chr1", chr1_q, m_regs[2]);
        check_one(tag, "prg",  prg_q,  m_regs[3]);
    endtask

    task automatic do_write(logic [1:0] sel, logic [7:0] d, logic signed [31:0] s, string tag);
        @(negedge clk);
        wr_en = 1'b1; addr_sel = sel; wr_data = d; cyc_stamp = s;
        @(negedge clk);
        wr_en = 1'b0;
        addr_sel = ~sel; wr_data = ~d;
        model_write(sel, d, s);
        check_all(tag);
    endtask

    // five writes, data bit 0 carries the value LSB first; bits 6:1 take noise
    task automatic load_reg(logic [1:0] sel, logic [4:0] v, string tag);
        for (int i = 0; i < 5; i++) begin
            now_stamp += 3;
            do_write(sel, {1'b0, 6'($urandom), v[i]}, 32'(now_stamp), tag);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R8: first stamp equals the reset value of the stored stamp
        do_write(2'd1, 8'h01, -1, "R8");
        now_stamp = 10;
        load_reg(2'd1, 5'b1011_0, "R2");
        load_reg(2'd2, 5'b0100_1, "R3");
        load_reg(2'd3, 5'b1110_0, "R3");
        load_reg(2'd0, 5'b0001_1, "R3");
        load_reg(2'd1, 5'b0111_1, "R4");

        // R5: abort mid-load, then a fresh five-write load
        now_stamp += 3; do_write(2'd2, 8'h01, 32'(now_stamp), "R5");
        now_stamp += 3; do_write(2'd2, 8'h00, 32'(now_stamp), "R5");
        now_stamp += 3; do_write(2'd0, 8'h80, 32'(now_stamp), "R5");
        load_reg(2'd2, 5'b1000_1, "R5");
        load_reg(2'd0, 5'b1000_0, "R5");
        now_stamp += 3; do_write(2'd0, 8'hFE, 32'(now_stamp), "R5");

        // R6 and R7: chained close stamps and a backwards step
        now_stamp = 1000;
        do_write(2'd3, 8'h01, 1000, "R6");
        do_write(2'd3, 8'h01, 1001, "R7");
        do_write(2'd3, 8'h01, 1002, "R7");
        do_write(2'd3, 8'h00, 1001, "R6");
        do_write(2'd3, 8'h01, 1005, "R6");
        do_write(2'd3, 8'h00, 1008, "R6");
        do_write(2'd3, 8'h01, 1011, "R6");
        do_write(2'd3, 8'h80, 1012, "R6");

        // R9: signed wrap of the stamp
        do_write(2'd1, 8'h80, 32'h7FFF_FFF0, "R9");
        for (int i = 0; i < 4; i++) do_write(2'd1, 8'h01, 32'h7FFF_FFF0 + 32'(3 * (i + 1)), "R9");
        do_write(2'd1, 8'h01, 32'h7FFF_FFFF, "R9");
        do_write(2'd1, 8'h00, 32'h8000_0000, "R9");

        // R11: sixth write starts over
        now_stamp = 5000;
        load_reg(2'd2, 5'b1010_1, "R11");
        now_stamp += 3; do_write(2'd2, 8'h01, 32'(now_stamp), "R11");
        load_reg(2'd2, 5'b0000_0, "R11");

        // R10: idle bus with noisy inputs
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            addr_sel = 2'($urandom); wr_data = 8'($urandom); cyc_stamp = 32'($urandom);
            @(negedge clk);
            check_all("R10");
        end

        // random mix across R2 R3 R5 R6 R7
        now_stamp = 20000;
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] d = 8'($urandom);
            int step = int'($urandom % 4);
            if (($urandom % 8) != 0) d[7] = 1'b0;
            if (($urandom % 3) == 0) now_stamp -= step; else now_stamp += step;
            do_write(2'($urandom), d, 32'(now_stamp), "R2 R3 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule